// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a timer/counter that generates centre-aligned pulse-width-modulated waveforms. On every cycle in which the timer-clock enable is high, the counter takes one step. It climbs from zero to a TOP value, turns round and descends back to zero, and then repeats. TOP comes from either a dedicated period register or the first compare channel. A control field chooses between the two.

Each compare channel has a software-visible buffer and an active copy. The counter samples every buffered value, including TOP, only when it is at zero. Because of this, a period is never changed once it has started, and the rising and falling halves of every period have the same length. Each channel drives one waveform pin, in normal or inverted polarity, or holds the pin low. Three sticky event flags mark the following points: a channel match, the counter reaching TOP, and the counter passing through zero. Software clears a flag by writing a one to it.

Top module: `pfc_pwm_timer`

## Requirements
- R1: After reset the count is 0, and the counter advances only on cycles with `tick_i` high. From 0 it steps up by one per tick to TOP, holds TOP for exactly one tick, and then steps down by one per tick to 0.
- R2: Control register address 5 holds the TOP source in bits [3:0]. Code 9 takes TOP from the compare-0 buffer, and any other code (nominally 8) takes TOP from the period register at address 4. TOP is sampled only on the tick at count 0, and a sampled value below 3 is used as 3.
- R3: Addresses 0, 1 and 2 write the buffers of compare channels 0, 1 and 2. A channel's active compare value is reloaded from its buffer only on the tick at count 0.
- R4: The overflow flag is set on the tick at count 0, which is the same tick that reloads the active values. It becomes visible one clock later.
- R5: On the tick at count TOP, the compare-0 flag is set when TOP comes from compare 0. Otherwise the period flag is set. The flag becomes visible one clock later.
- R6: A channel's compare flag is set on any tick at which the count equals its active compare value. A compare value above TOP never sets the flag and never changes the output.
- R7: Output mode 2 is in control bits [5+2i:4+2i] for channel i. In this mode the output is cleared on a match while counting up and set on a match while counting down. Count 0 counts as upward and count TOP counts as downward.
- R8: Output mode 3 applies the opposite actions: it sets the output on an upward match and clears it on a downward match.
- R9: Output modes 0 and 1 hold the channel output low. The reset mode is 0.
- R10: A flag stays set until a one is written to its clear input. If a clear and a set arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer-clock enable, one counter step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 to 2 compare buffers, 4 period register, 5 control |
| wr_data_i | input | 16 | Write data |
| cmp_clr_i | input | 3 | Write-one-to-clear for the compare flags |
| cap_clr_i | input | 1 | Write-one-to-clear for the period flag |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| count_o | output | 16 | Current count |
| cmp_flag_o | output | 3 | Compare-match flags |
| cap_flag_o | output | 1 | Period-register TOP flag |
| ovf_flag_o | output | 1 | Overflow (count 0) flag |
| wave_o | output | 3 | Waveform outputs |

## Verification
Every result is registered off the counter value present at a tick edge, so each one is due one clock after that value is shown on `count_o`. This applies to a flag after a match, TOP or zero, to an output edge after a match, and to a new count after TOP. The bench holds the enable high and waits, on falling edges, for a given count in a given direction. It then samples on the next falling edge, or on that same edge when it checks that an event has not yet taken effect. Values written to the buffers are expected to act only after the next pass through zero, and the checks therefore start one full period after the write.

// File: rtl/pfc_pwm_pkg.sv
package pfc_pwm_pkg;
  localparam int unsigned MIN_TOP  = 3;
  localparam int unsigned SRC_CAP  = 8;
  localparam int unsigned SRC_CMP0 = 9;
  localparam int unsigned ADDR_CAP  = 4;
  localparam int unsigned ADDR_CTRL = 5;
  localparam int unsigned SRC_W     = 4;

  typedef enum logic [1:0] {
    OUT_OFF0   = 2'd0,
    OUT_OFF1   = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;
endpackage

// File: rtl/pfc_pwm_counter.sv
module pfc_pwm_counter
  import pfc_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_src_i,
  input  logic             sel_cmp0_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] top_eff_o,
  output logic             sel_cmp0_eff_o,
  output logic             at_bottom_o,
  output logic             up_phase_o
);
  localparam logic [CNT_W-1:0] MinTopV = CNT_W'(MIN_TOP);

  logic [CNT_W-1:0] cnt_q, top_q, top_clamped;
  logic             dir_up_q, sel_q;

  assign at_bottom_o    = (cnt_q == '0);
  assign top_clamped    = (top_src_i < MinTopV) ? MinTopV : top_src_i;
  // period values are only taken at zero
  assign top_eff_o      = at_bottom_o ? top_clamped : top_q;
  assign sel_cmp0_eff_o = at_bottom_o ? sel_cmp0_i : sel_q;
  // zero belongs to the rising slope, TOP to the falling one
  assign up_phase_o     = at_bottom_o || (dir_up_q && (cnt_q != top_eff_o));
  assign cnt_o          = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
      top_q    <= MinTopV;
      sel_q    <= 1'b0;
    end else if (tick_i) begin
      if (at_bottom_o) begin
        top_q    <= top_clamped;
        sel_q    <= sel_cmp0_i;
        dir_up_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
      end else if (dir_up_q && (cnt_q == top_q)) begin
        dir_up_q <= 1'b0;
        cnt_q    <= cnt_q - 1'b1;
      end else if (dir_up_q) begin
        cnt_q    <= cnt_q + 1'b1;
      end else begin
        cnt_q    <= cnt_q - 1'b1;
      end
    end
  end

  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  a_r1_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_bottom_o && dir_up_q && (cnt_q != top_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r1_turn_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_bottom_o && (cnt_q == top_q)) |=> (!dir_up_q && (cnt_q == $past(cnt_q) - 1'b1)));
  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= top_eff_o);
  a_r2_top_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_bottom_o) |=> $stable(top_q));
endmodule

// File: rtl/pfc_pwm_channel.sv
module pfc_pwm_channel
  import pfc_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             at_bottom_i,
  input  logic             up_phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] top_eff_i,
  input  logic [1:0]       out_mode_i,
  output logic [CNT_W-1:0] cmp_buf_o,
  output logic             match_o,
  output logic             wave_o
);
  logic [CNT_W-1:0] buf_q, act_q, cmp_eff;
  logic             wave_q;
  out_mode_e        mode;

  assign mode      = out_mode_e'(out_mode_i);
  assign cmp_eff   = at_bottom_i ? buf_q : act_q;
  assign match_o   = tick_i && (cmp_eff <= top_eff_i) && (cnt_i == cmp_eff);
  assign cmp_buf_o = buf_q;
  assign wave_o    = wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (wr_i) buf_q <= wr_data_i;
      if (tick_i && at_bottom_i) act_q <= buf_q;
      case (mode)
        OUT_NONINV: if (match_o) wave_q <= !up_phase_i;
        OUT_INV:    if (match_o) wave_q <= up_phase_i;
        default:    wave_q <= 1'b0;
      endcase
    end
  end

  a_r3_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && at_bottom_i) |=> $stable(act_q));
  a_r7_wave_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_o && out_mode_i[1]) |=> $stable(wave_q));
  a_r9_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_mode_i[1] |=> !wave_q);
endmodule

// File: rtl/pfc_pwm_flag.sv
module pfc_pwm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (flag_q && !clr_i) || set_i;
  end

  assign flag_o = flag_q;

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/pfc_pwm_timer.sv
module pfc_pwm_timer
  import pfc_pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 3,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [N_CH-1:0]   cmp_clr_i,
  input  logic              cap_clr_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_CH-1:0]   cmp_flag_o,
  output logic              cap_flag_o,
  output logic              ovf_flag_o,
  output logic [N_CH-1:0]   wave_o
);
  localparam int unsigned CTRL_W = SRC_W + 2 * N_CH;

  logic [CNT_W-1:0]            cap_q;
  logic [SRC_W-1:0]            src_q;
  logic [N_CH-1:0][1:0]        omode_q;
  logic [N_CH-1:0][CNT_W-1:0]  cmp_buf;
  logic [N_CH-1:0]             match, cmp_set;
  logic [CNT_W-1:0]            cnt, top_eff, top_src;
  logic                        sel_cmp0, sel_eff, at_bottom, up_phase, top_hit;
  logic                        wr_cap, wr_ctrl;

  assign wr_cap   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CAP));
  assign wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_cmp0 = (src_q == SRC_W'(SRC_CMP0));
  assign top_src  = sel_cmp0 ? cmp_buf[0] : cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '1;
      src_q   <= SRC_W'(SRC_CAP);
      omode_q <= '0;
    end else begin
      if (wr_cap) cap_q <= wr_data_i;
      if (wr_ctrl) begin
        src_q   <= wr_data_i[SRC_W-1:0];
        omode_q <= wr_data_i[CTRL_W-1:SRC_W];
      end
    end
  end

  pfc_pwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .top_src_i     (top_src),
    .sel_cmp0_i    (sel_cmp0),
    .cnt_o         (cnt),
    .top_eff_o     (top_eff),
    .sel_cmp0_eff_o(sel_eff),
    .at_bottom_o   (at_bottom),
    .up_phase_o    (up_phase)
  );

  assign top_hit = tick_i && !at_bottom && (cnt == top_eff);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en_i && (wr_addr_i == ADDR_W'(i));

    pfc_pwm_channel #(.CNT_W(CNT_W)) u_channel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .wr_i       (ch_wr),
      .wr_data_i  (wr_data_i),
      .at_bottom_i(at_bottom),
      .up_phase_i (up_phase),
      .cnt_i      (cnt),
      .top_eff_i  (top_eff),
      .out_mode_i (omode_q[i]),
      .cmp_buf_o  (cmp_buf[i]),
      .match_o    (match[i]),
      .wave_o     (wave_o[i])
    );

    if (i == 0) begin : g_top_src
      assign cmp_set[i] = match[i] || (top_hit && sel_eff);
    end else begin : g_plain
      assign cmp_set[i] = match[i];
    end

    pfc_pwm_flag u_cmp_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (cmp_set[i]),
      .clr_i (cmp_clr_i[i]),
      .flag_o(cmp_flag_o[i])
    );
  end

  pfc_pwm_flag u_cap_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (top_hit && !sel_eff),
    .clr_i (cap_clr_i),
    .flag_o(cap_flag_o)
  );

  pfc_pwm_flag u_ovf_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (tick_i && at_bottom),
    .clr_i (ovf_clr_i),
    .flag_o(ovf_flag_o)
  );

  assign count_o = cnt;

  a_r4_ovf_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (count_o == '0)) |=> ovf_flag_o);
  a_r5_cap_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_hit && !sel_eff) |=> cap_flag_o);
  a_r5_cmp0_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_hit && sel_eff) |=> cmp_flag_o[0]);
endmodule

// File: tb/pfc_pwm_timer_bench.sv
`timescale 1ns/1ps
module pfc_pwm_timer_bench;
  localparam int CNT_W = 16;
  localparam int N_CH  = 3;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              tick_i;
  logic              wr_en_i;
  logic [2:0]        wr_addr_i;
  logic [CNT_W-1:0]  wr_data_i;
  logic [N_CH-1:0]   cmp_clr_i;
  logic              cap_clr_i, ovf_clr_i;
  logic [CNT_W-1:0]  count_o;
  logic [N_CH-1:0]   cmp_flag_o, wave_o;
  logic              cap_flag_o, ovf_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pfc_pwm_timer #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(3)) u_pfc_pwm_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .cmp_clr_i(cmp_clr_i), .cap_clr_i(cap_clr_i), .ovf_clr_i(ovf_clr_i),
    .count_o(count_o), .cmp_flag_o(cmp_flag_o), .cap_flag_o(cap_flag_o),
    .ovf_flag_o(ovf_flag_o), .wave_o(wave_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl(input int src, input int m0, input int m1, input int m2);
    return 16'((src & 15) | ((m0 & 3) << 4) | ((m1 & 3) << 6) | ((m2 & 3) << 8));
  endfunction

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 16'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_clr(input logic [N_CH-1:0] c, input logic cap, input logic ovf);
    cmp_clr_i = c; cap_clr_i = cap; ovf_clr_i = ovf;
    @(negedge clk);
    cmp_clr_i = '0; cap_clr_i = 1'b0; ovf_clr_i = 1'b0;
  endtask

  // wait for a falling edge where the count shows v, reached in the given direction
  task automatic goto(input int v, input bit up);
    int p;
    p = int'(count_o);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (int'(count_o) == v && (up ? (p < v) : (p > v))) return;
      p = int'(count_o);
    end
    chk("goto timeout", 0, 1);
  endtask

  task automatic t_sequence();
    goto(0, 1'b0);
    for (int k = 1; k < 20; k++) begin
      @(negedge clk);
      chk("R1 count sequence", int'(count_o), (k <= 9) ? k : (k == 19 ? 1 : 18 - k));
    end
  endtask

  task automatic t_tick_gate();
    int v;
    tick_i = 1'b0;
    v = int'(count_o);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 no step without tick", int'(count_o), v);
    end
    tick_i = 1'b1;
    @(negedge clk);
    chk("R1 step after tick", (int'(count_o) == v + 1) || (int'(count_o) == v - 1), 1);
  endtask

  task automatic t_ovf();
    goto(3, 1'b1);
    pulse_clr('0, 1'b0, 1'b1);
    goto(0, 1'b0);
    chk("R4 overflow not before zero tick", ovf_flag_o, 0);
    @(negedge clk);
    chk("R4 overflow after zero tick", ovf_flag_o, 1);
  endtask

  task automatic t_top_cap();
    goto(3, 1'b1);
    pulse_clr(3'b001, 1'b1, 1'b0);
    goto(9, 1'b1);
    chk("R5 period flag not before TOP tick", cap_flag_o, 0);
    @(negedge clk);
    chk("R5 period flag after TOP tick", cap_flag_o, 1);
    chk("R5 compare0 flag quiet when period register is TOP", cmp_flag_o[0], 0);
    chk("R1 count after TOP", int'(count_o), 8);
  endtask

  task automatic t_buffer();
    goto(2, 1'b1);
    wr(1, 5);
    goto(7, 1'b1);
    pulse_clr(3'b010, 1'b0, 1'b0);
    goto(1, 1'b0);
    chk("R3 buffered compare not yet active", cmp_flag_o[1], 0);
    goto(5, 1'b1);
    @(negedge clk);
    chk("R6 match flag after reload", cmp_flag_o[1], 1);
  endtask

  task automatic t_noninv();
    wr(5, ctrl(8, 0, 2, 0));
    goto(9, 1'b1);
    goto(7, 1'b0); chk("R7 noninv 7 down", wave_o[1], 0);
    goto(3, 1'b0); chk("R7 noninv 3 down", wave_o[1], 1);
    goto(3, 1'b1); chk("R7 noninv 3 up", wave_o[1], 1);
    goto(7, 1'b1); chk("R7 noninv 7 up", wave_o[1], 0);
  endtask

  task automatic t_inv();
    wr(2, 5);
    wr(5, ctrl(8, 0, 2, 3));
    goto(0, 1'b0);
    goto(9, 1'b1);
    goto(7, 1'b0); chk("R8 inv 7 down", wave_o[2], 1);
    goto(3, 1'b0); chk("R8 inv 3 down", wave_o[2], 0);
    goto(3, 1'b1); chk("R8 inv 3 up", wave_o[2], 0);
    goto(7, 1'b1); chk("R8 inv 7 up", wave_o[2], 1);
  endtask

  task automatic t_off();
    wr(0, 4);
    wr(5, ctrl(8, 1, 2, 3));
    goto(0, 1'b0);
    goto(3, 1'b1); chk("R9 off 3 up", wave_o[0], 0);
    goto(6, 1'b1); chk("R9 off 6 up", wave_o[0], 0);
    goto(2, 1'b0); chk("R9 off 2 down", wave_o[0], 0);
  endtask

  task automatic t_unreach();
    int w;
    wr(2, 12);
    goto(0, 1'b0);
    @(negedge clk);
    pulse_clr(3'b100, 1'b0, 1'b0);
    w = int'(wave_o[2]);
    goto(9, 1'b1);  chk("R6 unreachable wave at TOP", wave_o[2], w);
    goto(0, 1'b0);  chk("R6 unreachable wave at zero", wave_o[2], w);
    chk("R6 unreachable flag stays clear", cmp_flag_o[2], 0);
  endtask

  task automatic t_top_cmp0();
    wr(0, 6);
    wr(5, ctrl(9, 1, 2, 3));
    goto(0, 1'b0);
    @(negedge clk);
    pulse_clr(3'b001, 1'b1, 1'b0);
    goto(6, 1'b1);
    @(negedge clk);
    chk("R2 compare0 TOP turns at 6", int'(count_o), 5);
    chk("R5 compare0 flag at TOP", cmp_flag_o[0], 1);
    chk("R5 period flag quiet with compare0 TOP", cap_flag_o, 0);
  endtask

  task automatic t_clamp();
    int mx;
    wr(0, 1);
    goto(0, 1'b0);
    mx = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (int'(count_o) > mx) mx = int'(count_o);
      if (count_o == '0) break;
    end
    chk("R2 TOP below 3 used as 3", mx, 3);
  endtask

  task automatic t_w1c();
    goto(0, 1'b0);
    pulse_clr('0, 1'b0, 1'b1);
    chk("R10 set beats clear", ovf_flag_o, 1);
    pulse_clr('0, 1'b0, 1'b1);
    chk("R10 clear without set", ovf_flag_o, 0);
    @(negedge clk);
    chk("R10 stays clear", ovf_flag_o, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst_ni = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    cmp_clr_i = '0; cap_clr_i = 1'b0; ovf_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count_o), 0);
    chk("R10 reset flags", int'({cmp_flag_o, cap_flag_o, ovf_flag_o}), 0);
    chk("R9 reset outputs low", int'(wave_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    wr(4, 9);
    wr(0, 20);
    wr(1, 0);
    wr(2, 0);
    wr(5, ctrl(8, 0, 0, 0));
    tick_i = 1'b1;
    t_sequence();
    t_tick_gate();
    t_ovf();
    t_top_cap();
    t_buffer();
    t_noninv();
    t_inv();
    t_off();
    t_unreach();
    t_top_cmp0();
    t_clamp();
    t_w1c();
    done = 1'b1;
    summary();
  end
endmodule